// File: doc/BRIEF.md
# Pulse-Length to Inverse-Duration Encoder

This block watches a single serial input and measures how many consecutive clock cycles it stays high. Once the input drops, the block produces a single output pulse whose width is the inverse of the measured run: a one-cycle run gives a three-cycle pulse, a two-cycle run gives a two-cycle pulse, and a three-cycle run gives a one-cycle pulse. Runs longer than three cycles are treated as three-cycle runs.

The block is a small Moore state machine held in three flip-flops. It has an idle state, three states that count the run, and three states that drive the output down to zero. The output is taken straight from one state bit. While the output pulse is being driven, the input is ignored. A new run is only measured after the machine is back in idle. A synchronous reset returns the block to idle.

Top module: `pulse_inv_encoder`

## Requirements
- R1: When `rst` is sampled high at a rising edge, `z` is 0 after that edge and the block is idle. This holds even if reset arrives in the middle of an output pulse.
- R2: `z` stays 0 while the machine is idle, and while `x` is still being sampled high during a run.
- R3: A run of exactly one high sample, followed by a low sample, drives `z` high for exactly 3 cycles. These cycles start right after the edge that samples `x` low.
- R4: A run of exactly two high samples drives `z` high for exactly 2 cycles. These cycles start right after the edge that samples `x` low.
- R5: A run of exactly three high samples drives `z` high for exactly 1 cycle. This cycle starts right after the edge that samples `x` low.
- R6: A run of four or more high samples drives `z` high for exactly 1 cycle once `x` is sampled low.
- R7: The value of `x` has no effect while `z` is high. After the last high output cycle the machine is idle. The next run starts at the first high sample of `x` taken in idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| x | input | 1 | Serial input whose high runs are measured |
| z | output | 1 | Output pulse, width inverse to the run length |

## Verification
The hardest case to reach is an input that is still high, or rises again, while the output pulse is running. A correct design must not let that activity start a new measurement until idle is reached. An input that stays high across the last output cycle is also hard, because it must be counted from idle and not from the output states. Directed sequences hold `x` high through a whole output pulse, and drop it exactly at the pulse boundary. A long stretch of random runs, one to five cycles high with gaps of zero to five cycles, lands input edges at every offset of every output pulse. Every cycle is checked against an independent run-length model.

// File: rtl/pulse_inv_encoder.sv
module pulse_inv_encoder (
  input  logic clk,
  input  logic rst,
  input  logic x,
  output logic z
);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_C1   = 3'd1,
    S_C2   = 3'd2,
    S_C3   = 3'd3,
    S_O1   = 3'd4,
    S_O2   = 3'd5,
    S_O3   = 3'd6
  } state_t;

  state_t state, nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE: nxt = x ? S_C1 : S_IDLE;
      S_C1:   nxt = x ? S_C2 : S_O3;
      S_C2:   nxt = x ? S_C3 : S_O2;
      S_C3:   nxt = x ? S_C3 : S_O1;
      S_O3:   nxt = S_O2;
      S_O2:   nxt = S_O1;
      S_O1:   nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nxt;
  end

  assign z = state[2];

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!z && state == S_IDLE)); // R1
  AST_IDLE_HIGH_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && x) |=> !z); // R2
  AST_ONE_GIVES_PULSE: assert property (@(posedge clk) disable iff (rst)
    (state == S_C1 && !x) |=> z); // R3
  AST_PULSE_MAX3: assert property (@(posedge clk) disable iff (rst)
    (z && $past(z) && $past(z, 2)) |=> !z); // R3
  AST_THREE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (state == S_C3 && !x) |=> (z && state == S_O1)); // R5
  AST_OUT_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
    z |=> (z || state == S_IDLE)); // R7

endmodule

// File: tb/pulse_inv_encoder_tb.sv
module pulse_inv_encoder_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x = 1'b0;
  logic z;

  int total = 0;
  int bad = 0;
  int run_len = 0;
  int rem = 0;
  int src = 0;
  bit done = 1'b0;

  pulse_inv_encoder u_dut (.clk(clk), .rst(rst), .x(x), .z(z));

  always #2 clk = ~clk;

  function automatic string tag_of();
    if (rem == 0) return "R2";
    if (src == 1) return "R3";
    if (src == 2) return "R4";
    if (src == 3) return "R5";
    return "R6";
  endfunction

  function automatic int width_for(int n);
    return (n >= 3) ? 1 : 4 - n;
  endfunction

  task automatic chk(string tag);
    bit e;
    e = (rem > 0);
    total++;
    if (z !== e) begin
      bad++;
      $display("FAIL %s: z=%0b expected %0b", tag, z, e);
    end
  endtask

  task automatic cyc(bit xv, bit rv, string tag);
    @(negedge clk);
    chk(tag == "" ? tag_of() : tag);
    x = xv;
    rst = rv;
    @(posedge clk);
    if (rv) begin
      rem = 0; run_len = 0;
    end else if (rem > 0) begin
      rem--;
    end else if (run_len > 0) begin
      if (xv) run_len++;
      else begin
        src = run_len;
        rem = width_for(run_len);
        run_len = 0;
      end
    end else if (xv) begin
      run_len = 1;
    end
  endtask

  task automatic group(int n, int gap, string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, tag);
    for (int i = 0; i < gap; i++) cyc(1'b0, 1'b0, tag);
  endtask

  initial begin
    int seed;
    seed = $urandom(2024);
    cyc(1'b0, 1'b1, "R1");
    cyc(1'b0, 1'b1, "R1");
    cyc(1'b0, 1'b0, "R1");
    group(1, 6, "R3");
    group(2, 6, "R4");
    group(3, 6, "R5");
    group(6, 6, "R6");
    group(1, 1, "R7");
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, "R7");
    group(0, 6, "R7");
    group(1, 3, "R7");
    group(2, 6, "R7");
    group(1, 2, "R1");
    cyc(1'b0, 1'b1, "R1");
    cyc(1'b0, 1'b0, "R1");
    cyc(1'b0, 1'b0, "R1");
    for (int k = 0; k < 1500; k++) begin
      int h = 1 + ($urandom % 5);
      int g = $urandom % 6;
      group(h, g, "");
    end
    group(0, 6, "");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R7: watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule